// File: doc/BRIEF.md
# PWM Reload Controller with Armed Double Buffering

This block sits between software and a PWM counter. Software writes a prescaler select, a counter modulus and one duty word per channel into shadow registers. Those values reach the active outputs that feed the counter and comparators only at a reload point, which the counter signals with a one-cycle strobe. A transfer happens only when software has armed a load-ok flag.

The load-ok flag is set by a two-step handshake. Software first reads the control register while the flag is clear, and then writes 1 to the flag bit. The flag clears itself when the transfer happens. The same control register holds the generator run bit and a sticky interrupt flag. That interrupt flag sets at every reload point while the generator runs, whether or not a transfer took place.

Output pins are enabled while the generator runs. An external override input can also enable them while the generator is stopped.

Top module: `pwm_reload_ctrl`

Register map (word addresses):
- control at 0: bit 0 run, bit 1 load-ok, bit 2 interrupt flag.
- prescaler at 1: bits [PS_W-1:0].
- modulus at 2: bits [MOD_W-1:0].
- duty of channel k at 4+k: bits [DUTY_W-1:0].

All other bits read as 0.

## Requirements
- R1: The load-ok flag (control bit 1) becomes 1 only when a control write with bit 1 = 1 follows a control read that saw the flag at 0. A write of bit 1 = 1 without that read leaves the flag at 0.
- R2: When the flag is 1 at a reload strobe, the prescaler, modulus and every duty shadow are copied to the active outputs, visible on the cycle after the strobe.
- R3: The flag reads 0 after a reload strobe that found it set.
- R4: When the flag is 0 at a reload strobe, the active outputs keep their previous values.
- R5: After reset the flag, the run bit and the interrupt flag read 0, and all active outputs are 0.
- R6: At every reload strobe while the run bit is 1, the interrupt flag (control bit 2, also driven on `irq`) is set, whatever the state of the load-ok flag. Writing 1 to control bit 2 clears it.
- R7: While the run bit is 0, `gen_run` is 0 and `pin_oe` is 0 unless `ovr_out_ctl` is 1, in which case `pin_oe` is 1.
- R8: Writing 1 to control bit 0 drives both `gen_run` and `pin_oe` to 1.
- R9: Writes to the shadow registers never change the active outputs.
- R10: Any control write that does not set the flag cancels a pending arm. A later write of 1 to bit 1 then has no effect.
- R11: Writing 0 to control bit 1 while the flag is set clears it, and the next reload strobe then transfers nothing.
- R12: A reload strobe while the run bit is 0 leaves the interrupt flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms the flag when reading control) |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the addressed register, combinational |
| reload_pt | input | 1 | One-cycle reload strobe from the PWM counter |
| ovr_out_ctl | input | 1 | Output-control override, enables pins while stopped |
| act_prescale | output | PS_W | Active prescaler select |
| act_modulus | output | MOD_W | Active counter modulus |
| act_duty | output | NCH*DUTY_W | Active duty words, channel k at bits [k*DUTY_W +: DUTY_W] |
| gen_run | output | 1 | Generator enable |
| pin_oe | output | 1 | Pin output enable (0 means high impedance) |
| irq | output | 1 | Interrupt request, equal to the interrupt flag |

## Verification
The bench builds the block with two channels and 10-bit modulus and duty words. With these widths, an all-ones modulus and duty patterns that set the top bit of each field fill the fields completely. They also show whether the channel slices are packed in the right order on `act_duty`. A two-channel build keeps the generate loops short while still exercising more than one slice. The stimulus walks through the arm, cancel, manual-clear and self-clear paths. It then checks that a reload with the flag clear still raises the interrupt only while the generator runs.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;
  // Word addresses of the software-visible registers
  localparam int unsigned RA_CTRL  = 0;
  localparam int unsigned RA_PRESC = 1;
  localparam int unsigned RA_MOD   = 2;
  localparam int unsigned RA_DUTY0 = 4;
  // Bit positions inside the control register
  localparam int unsigned CB_RUN = 0;
  localparam int unsigned CB_LOK = 1;
  localparam int unsigned CB_IRQ = 2;
endpackage

// File: rtl/pwm_reload_regs.sv
module pwm_reload_regs
  import pwm_reload_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PS_W   = 2,
  parameter int unsigned MOD_W  = 12,
  parameter int unsigned DUTY_W = 12,
  parameter int unsigned NCH    = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [PS_W-1:0]         sh_presc,
  output logic [MOD_W-1:0]        sh_mod,
  output logic [NCH*DUTY_W-1:0]   sh_duty
);
  logic unused_wdata;
  logic presc_en, mod_en;
  logic [PS_W-1:0]  presc_q, presc_d;
  logic [MOD_W-1:0] mod_q, mod_d;

  assign unused_wdata = ^wdata;

  always_comb begin
    presc_en = wr && (addr == ADDR_W'(RA_PRESC));
    mod_en   = wr && (addr == ADDR_W'(RA_MOD));
    presc_d  = wdata[PS_W-1:0];
    mod_d    = wdata[MOD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      mod_q   <= '0;
    end else begin
      if (presc_en) presc_q <= presc_d;
      if (mod_en)   mod_q   <= mod_d;
    end
  end

  assign sh_presc = presc_q;
  assign sh_mod   = mod_q;

  for (genvar g = 0; g < NCH; g++) begin : g_duty
    logic              we;
    logic [DUTY_W-1:0] q;
    assign we = wr && (addr == ADDR_W'(RA_DUTY0 + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata[DUTY_W-1:0];
    end
    assign sh_duty[g*DUTY_W +: DUTY_W] = q;
  end
endmodule

// File: rtl/pwm_reload_flags.sv
module pwm_reload_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic rd_ctrl,
  input  logic w_run,
  input  logic w_lok,
  input  logic w_irq,
  input  logic reload_pt,
  output logic run_en,
  output logic lok,
  output logic irq_flag,
  output logic arm,
  output logic xfer
);
  logic run_q, run_d;
  logic lok_q, lok_d;
  logic irq_q, irq_d;
  logic arm_q, arm_d;

  always_comb begin
    xfer  = lok_q && reload_pt;
    run_d = wr_ctrl ? w_run : run_q;

    // Arm: a control read that sees the flag clear; any control write drops it
    arm_d = arm_q;
    if (wr_ctrl)                arm_d = 1'b0;
    else if (rd_ctrl && !lok_q) arm_d = 1'b1;

    // Load-ok: transfer clears with priority, then software write
    lok_d = lok_q;
    if (xfer)                   lok_d = 1'b0;
    else if (wr_ctrl) begin
      if (!w_lok)               lok_d = 1'b0;
      else if (arm_q)           lok_d = 1'b1;
    end

    // Interrupt: write-one-to-clear, a reload while running wins
    irq_d = irq_q;
    if (wr_ctrl && w_irq)       irq_d = 1'b0;
    if (reload_pt && run_q)     irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      lok_q <= 1'b0;
      irq_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      run_q <= run_d;
      lok_q <= lok_d;
      irq_q <= irq_d;
      arm_q <= arm_d;
    end
  end

  assign run_en   = run_q;
  assign lok      = lok_q;
  assign irq_flag = irq_q;
  assign arm      = arm_q;
endmodule

// File: rtl/pwm_reload_active.sv
module pwm_reload_active #(
  parameter int unsigned PS_W   = 2,
  parameter int unsigned MOD_W  = 12,
  parameter int unsigned DUTY_W = 12,
  parameter int unsigned NCH    = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  xfer,
  input  logic [PS_W-1:0]       sh_presc,
  input  logic [MOD_W-1:0]      sh_mod,
  input  logic [NCH*DUTY_W-1:0] sh_duty,
  output logic [PS_W-1:0]       act_presc,
  output logic [MOD_W-1:0]      act_mod,
  output logic [NCH*DUTY_W-1:0] act_duty
);
  logic [PS_W-1:0]  presc_q;
  logic [MOD_W-1:0] mod_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      mod_q   <= '0;
    end else if (xfer) begin
      presc_q <= sh_presc;
      mod_q   <= sh_mod;
    end
  end

  assign act_presc = presc_q;
  assign act_mod   = mod_q;

  for (genvar g = 0; g < NCH; g++) begin : g_act
    logic [DUTY_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (xfer) q <= sh_duty[g*DUTY_W +: DUTY_W];
    end
    assign act_duty[g*DUTY_W +: DUTY_W] = q;
  end
endmodule

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl
  import pwm_reload_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PS_W   = 2,
  parameter int unsigned MOD_W  = 12,
  parameter int unsigned DUTY_W = 12,
  parameter int unsigned NCH    = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic                    reg_rd,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  input  logic                    reload_pt,
  input  logic                    ovr_out_ctl,
  output logic [PS_W-1:0]         act_prescale,
  output logic [MOD_W-1:0]        act_modulus,
  output logic [NCH*DUTY_W-1:0]   act_duty,
  output logic                    gen_run,
  output logic                    pin_oe,
  output logic                    irq
);
  localparam int unsigned SYNC_N = 2;

  logic [SYNC_N-1:0]     rst_sync_q;
  logic                  rst_int_n;
  logic                  wr_ctrl, rd_ctrl;
  logic                  w_run, w_lok, w_irq;
  logic                  run_en, lok, irq_flag, arm, xfer;
  logic [PS_W-1:0]       sh_presc;
  logic [MOD_W-1:0]      sh_mod;
  logic [NCH*DUTY_W-1:0] sh_duty;
  logic [DATA_W-1:0]     rdata_c;

  // Reset: asserted asynchronously, released after SYNC_N clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  always_comb begin
    wr_ctrl = reg_wr && (reg_addr == ADDR_W'(RA_CTRL));
    rd_ctrl = reg_rd && (reg_addr == ADDR_W'(RA_CTRL));
    w_run   = reg_wdata[CB_RUN];
    w_lok   = reg_wdata[CB_LOK];
    w_irq   = reg_wdata[CB_IRQ];
  end

  pwm_reload_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PS_W(PS_W),
    .MOD_W(MOD_W), .DUTY_W(DUTY_W), .NCH(NCH)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .sh_presc(sh_presc),
    .sh_mod  (sh_mod),
    .sh_duty (sh_duty)
  );

  pwm_reload_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_ctrl  (wr_ctrl),
    .rd_ctrl  (rd_ctrl),
    .w_run    (w_run),
    .w_lok    (w_lok),
    .w_irq    (w_irq),
    .reload_pt(reload_pt),
    .run_en   (run_en),
    .lok      (lok),
    .irq_flag (irq_flag),
    .arm      (arm),
    .xfer     (xfer)
  );

  pwm_reload_active #(
    .PS_W(PS_W), .MOD_W(MOD_W), .DUTY_W(DUTY_W), .NCH(NCH)
  ) u_active (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .xfer     (xfer),
    .sh_presc (sh_presc),
    .sh_mod   (sh_mod),
    .sh_duty  (sh_duty),
    .act_presc(act_prescale),
    .act_mod  (act_modulus),
    .act_duty (act_duty)
  );

  // Read path: shadows and control bits, unused bits zero
  always_comb begin
    rdata_c = '0;
    if (reg_addr == ADDR_W'(RA_CTRL)) begin
      rdata_c[CB_RUN] = run_en;
      rdata_c[CB_LOK] = lok;
      rdata_c[CB_IRQ] = irq_flag;
    end
    if (reg_addr == ADDR_W'(RA_PRESC)) rdata_c[PS_W-1:0]  = sh_presc;
    if (reg_addr == ADDR_W'(RA_MOD))   rdata_c[MOD_W-1:0] = sh_mod;
    for (int k = 0; k < NCH; k++) begin
      if (reg_addr == ADDR_W'(RA_DUTY0 + k))
        rdata_c[DUTY_W-1:0] = sh_duty[k*DUTY_W +: DUTY_W];
    end
  end

  assign reg_rdata = rdata_c;
  assign gen_run   = run_en;
  assign pin_oe    = run_en || ovr_out_ctl;
  assign irq       = irq_flag;
endmodule

// File: rtl/pwm_reload_chk.sv
module pwm_reload_chk #(
  parameter int unsigned PS_W   = 2,
  parameter int unsigned MOD_W  = 12,
  parameter int unsigned DUTY_W = 12,
  parameter int unsigned NCH    = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_ctrl,
  input logic                  w_run,
  input logic                  w_lok,
  input logic                  reload_pt,
  input logic                  ovr,
  input logic                  run_en,
  input logic                  lok,
  input logic                  arm,
  input logic                  irq,
  input logic                  gen_run,
  input logic                  pin_oe,
  input logic [PS_W-1:0]       sh_presc,
  input logic [MOD_W-1:0]      sh_mod,
  input logic [NCH*DUTY_W-1:0] sh_duty,
  input logic [PS_W-1:0]       act_presc,
  input logic [MOD_W-1:0]      act_mod,
  input logic [NCH*DUTY_W-1:0] act_duty
);
  p_set_needs_arm_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lok) |-> $past(arm && wr_ctrl && w_lok));

  p_copy_on_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lok && reload_pt) |=> (act_presc == $past(sh_presc) && act_mod == $past(sh_mod)
                            && act_duty == $past(sh_duty)));

  p_self_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lok && reload_pt) |=> !lok);

  // also covers R9: shadow writes alone leave the active side untouched
  p_hold_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(lok && reload_pt) |=> ($stable(act_presc) && $stable(act_mod) && $stable(act_duty)));

  p_irq_on_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_pt && run_en) |=> irq);

  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !w_run && !ovr) |=> (!gen_run && (!pin_oe || ovr)));

  p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && w_run) |=> (gen_run && pin_oe));

  p_arm_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> !arm);

  p_manual_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !w_lok) |=> !lok);

  p_irq_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !(reload_pt && run_en)) |=> !irq);
endmodule

bind pwm_reload_ctrl pwm_reload_chk #(
  .PS_W(PS_W), .MOD_W(MOD_W), .DUTY_W(DUTY_W), .NCH(NCH)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .wr_ctrl  (wr_ctrl),
  .w_run    (w_run),
  .w_lok    (w_lok),
  .reload_pt(reload_pt),
  .ovr      (ovr_out_ctl),
  .run_en   (run_en),
  .lok      (lok),
  .arm      (arm),
  .irq      (irq),
  .gen_run  (gen_run),
  .pin_oe   (pin_oe),
  .sh_presc (sh_presc),
  .sh_mod   (sh_mod),
  .sh_duty  (sh_duty),
  .act_presc(act_prescale),
  .act_mod  (act_modulus),
  .act_duty (act_duty)
);

// File: tb/pwm_reload_ctrl_test.sv
`timescale 1ns/100ps
module pwm_reload_ctrl_test;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned PS_W   = 2;
  localparam int unsigned MOD_W  = 10;
  localparam int unsigned DUTY_W = 10;
  localparam int unsigned NCH    = 2;

  localparam int SEL_RD = 0, SEL_PS = 1, SEL_MOD = 2, SEL_DUTY = 3;
  localparam int SEL_OE = 4, SEL_RUN = 5, SEL_IRQ = 6;

  typedef struct {
    string       req;
    int          sel;
    logic [31:0] exp;
  } item_t;

  logic clk, rst_n, reg_wr, reg_rd, reload_pt, ovr_out_ctl;
  logic [ADDR_W-1:0]     reg_addr;
  logic [DATA_W-1:0]     reg_wdata, reg_rdata;
  logic [PS_W-1:0]       act_prescale;
  logic [MOD_W-1:0]      act_modulus;
  logic [NCH*DUTY_W-1:0] act_duty;
  logic gen_run, pin_oe, irq;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  item_t sb_q[$];
  event  chk_ev;

  pwm_reload_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PS_W(PS_W),
    .MOD_W(MOD_W), .DUTY_W(DUTY_W), .NCH(NCH)
  ) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reload_pt(reload_pt), .ovr_out_ctl(ovr_out_ctl),
    .act_prescale(act_prescale), .act_modulus(act_modulus), .act_duty(act_duty),
    .gen_run(gen_run), .pin_oe(pin_oe), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] grab(int sel);
    case (sel)
      SEL_RD:   return 32'(reg_rdata);
      SEL_PS:   return 32'(act_prescale);
      SEL_MOD:  return 32'(act_modulus);
      SEL_DUTY: return 32'(act_duty);
      SEL_OE:   return 32'(pin_oe);
      SEL_RUN:  return 32'(gen_run);
      default:  return 32'(irq);
    endcase
  endfunction

  // Monitor: pops expected items and compares with what the design shows
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it  = sb_q.pop_front();
        got = grab(it.sel);
        n_cmp++;
        if (got !== it.exp) begin
          n_bad++;
          $display("FAIL %s sel=%0d got=0x%0h exp=0x%0h", it.req, it.sel, got, it.exp);
        end
      end
    end
  end

  task automatic expect_val(input string req, input int sel, input logic [31:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sb_q.push_back(it);
    ->chk_ev;
    #1;
  endtask

  task automatic wr_reg(input int a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_ctrl(input string req, input logic [31:0] exp);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = '0;
    #1;
    expect_val(req, SEL_RD, exp);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse_reload();
    @(negedge clk);
    reload_pt = 1'b1;
    @(negedge clk);
    reload_pt = 1'b0;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reload_pt = 1'b0;
    ovr_out_ctl = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;

    // R5: reset state
    expect_val("R5", SEL_PS, 0);
    expect_val("R5", SEL_MOD, 0);
    expect_val("R5", SEL_DUTY, 0);
    expect_val("R5", SEL_RUN, 0);
    expect_val("R5", SEL_OE, 0);
    expect_val("R5", SEL_IRQ, 0);
    rd_ctrl("R5", 0);
    wr_reg(0, 16'h0000);                 // cancels the arm from that read (R10)

    // R9: shadow writes only
    wr_reg(1, 16'h0003);
    wr_reg(2, 16'h03FF);
    wr_reg(4, 16'h0155);
    wr_reg(5, 16'h02AA);
    expect_val("R9", SEL_MOD, 0);
    expect_val("R9", SEL_DUTY, 0);

    // R1: write of 1 without a preceding read is ignored
    wr_reg(0, 16'h0002);
    pulse_reload();
    expect_val("R1", SEL_MOD, 0);
    expect_val("R1", SEL_PS, 0);

    // R1/R2/R3: armed load
    rd_ctrl("R1", 0);
    wr_reg(0, 16'h0002);
    rd_ctrl("R1", 2);
    pulse_reload();
    expect_val("R2", SEL_PS, 3);
    expect_val("R2", SEL_MOD, 10'h3FF);
    expect_val("R2", SEL_DUTY, 32'({10'h2AA, 10'h155}));
    rd_ctrl("R3", 0);

    // R10 and R8: control write without setting the flag cancels the arm
    wr_reg(0, 16'h0001);
    expect_val("R8", SEL_RUN, 1);
    expect_val("R8", SEL_OE, 1);
    wr_reg(0, 16'h0003);
    rd_ctrl("R10", 1);

    // R4/R6: reload with the flag clear while running
    wr_reg(1, 16'h0001);
    wr_reg(2, 16'h00AB);
    wr_reg(4, 16'h0001);
    wr_reg(5, 16'h03FE);
    expect_val("R9", SEL_MOD, 10'h3FF);
    pulse_reload();
    expect_val("R4", SEL_MOD, 10'h3FF);
    expect_val("R4", SEL_PS, 3);
    expect_val("R4", SEL_DUTY, 32'({10'h2AA, 10'h155}));
    expect_val("R6", SEL_IRQ, 1);

    // R11: manual clear before the reload
    wr_reg(0, 16'h0003);
    wr_reg(0, 16'h0001);
    pulse_reload();
    expect_val("R11", SEL_MOD, 10'h3FF);
    expect_val("R11", SEL_PS, 3);
    rd_ctrl("R11", 5);

    // R6 clear by writing 1, R2 second transfer
    wr_reg(0, 16'h0007);
    rd_ctrl("R6", 3);
    pulse_reload();
    expect_val("R2", SEL_PS, 1);
    expect_val("R2", SEL_MOD, 10'h0AB);
    expect_val("R2", SEL_DUTY, 32'({10'h3FE, 10'h001}));
    expect_val("R6", SEL_IRQ, 1);
    rd_ctrl("R3", 5);

    // R7: stop, then override
    wr_reg(0, 16'h0004);
    expect_val("R7", SEL_RUN, 0);
    expect_val("R7", SEL_OE, 0);
    @(negedge clk);
    ovr_out_ctl = 1'b1;
    #1;
    expect_val("R7", SEL_OE, 1);
    expect_val("R7", SEL_RUN, 0);
    @(negedge clk);
    ovr_out_ctl = 1'b0;
    #1;
    expect_val("R7", SEL_OE, 0);

    // R12: reload while stopped leaves the interrupt flag clear
    pulse_reload();
    expect_val("R12", SEL_IRQ, 0);
    expect_val("R4", SEL_MOD, 10'h0AB);
    rd_ctrl("R12", 0);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule